// File: doc/BRIEF.md
# Two-Bit Overlay Cursor Compositor

This block places a 64x64 pointer image over a raster pixel stream. The image is stored at two bits per pixel in a small on-chip byte RAM, which stands in for display memory. For every beam coordinate the block decides whether the point lies inside the cursor window. If it does, the block looks up the pixel's two-bit code and replaces, keeps or inverts the incoming screen pixel. The result leaves the block two clock cycles after the beam coordinate and screen pixel arrive.

A host programs a small register set through a single write port. The set holds two cursor colours, an image base offset, horizontal and vertical presets, the screen position and a control word. The presets make the visible window start part-way into the array, so a cursor can be clipped at the left and top screen edges. The host moves the image start row through the base offset. Position, preset and offset writes are staged and become active only at a vertical-blank pulse. This keeps a frame from showing a half-moved cursor.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, and on the first output after reset, pix_out is zero. Reset clears the enable, the colours, the position, the presets and the offset.
- R2: While the enable is clear, pix_out equals the pix_in that was presented two cycles earlier, wherever the beam is.
- R3: Inside the window, code 2'b00 outputs colour 0 and 2'b01 outputs colour 1. Code 2'b10 outputs pix_in unchanged, and 2'b11 outputs the bitwise inverse of pix_in across all PIX_W bits.
- R4: The code for window column c and row r is read from byte address offset*8 + r*16 + c/4, where c already includes the horizontal preset. Inside that byte, column c uses bits [2*(c%4)+1 : 2*(c%4)], so the first pixel sits in bits 1:0.
- R5: The window covers posx <= beam_x < posx + 64 - hpre and posy <= beam_y < posy + 64 - vpre. Outside it, pix_out equals pix_in.
- R6: The horizontal preset shifts the fetched array column: window column beam_x - posx reads array column hpre + (beam_x - posx). The vertical preset only shortens the window, and the rows read start at row 0 of the offset.
- R7: The offset counts 8-byte units, so raising it by 2 starts the image one array row (16 bytes) later.
- R8: Writes to the position, preset and offset registers have no visible effect until a cycle with vblank_start high. From the cycle after that pulse, they apply.
- R9: A change on pix_in or on the beam inputs reaches pix_out after exactly two rising clock edges.
- R10: Only bit 7 of the control register (address 5) enables the cursor. The other bits have no effect.
- R11: Colour writes take effect at once, without waiting for vertical blank.
- R12: Register map on reg_addr: 0 = colour 0, 1 = colour 1, 2 = offset (bits 15:0), 3 = presets (vertical in 31:16, horizontal in 15:0), 4 = position (Y in 31:16, X in 15:0), 5 = control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| ram_we | input | 1 | Cursor image byte write strobe |
| ram_waddr | input | 11 | Cursor image byte address |
| ram_wdata | input | 8 | Cursor image byte data |
| beam_x | input | 16 | Current beam column |
| beam_y | input | 16 | Current beam row |
| pix_in | input | 32 | Underlying screen pixel |
| pix_out | output | 32 | Composited pixel |

## Verification
A wrong window bound or a wrong preset shows up as a cursor colour where the screen should pass through, or the reverse. It appears on the affected column or row two cycles after that beam coordinate is presented. A wrong byte address or bit-pair select changes which of the four actions a pixel takes, and neighbouring columns in one byte expose a pair error at once. A shadow register that loads early or late shows up as the old or new placement on the first pixel sampled after the write or after the blank pulse.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int CUR_DIM   = 64;
  localparam int ROW_BYTES = CUR_DIM / 4;
  localparam int IDX_W     = $clog2(CUR_DIM);
  localparam int REG_SEL_W = 3;

  localparam logic [REG_SEL_W-1:0] SEL_COL0   = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_COL1   = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_OFFSET = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_PRESET = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_POS    = 3'd4;
  localparam logic [REG_SEL_W-1:0] SEL_CTRL   = 3'd5;

  localparam int EN_BIT = 7;

  typedef enum logic [1:0] {
    CODE_COL0   = 2'b00,
    CODE_COL1   = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } cur_code_e;
endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cur_pkg::*;
#(
  parameter int PIX_W   = 32,
  parameter int COORD_W = 16,
  localparam int REG_W  = 2 * COORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_SEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 vblank_start,
  output logic [PIX_W-1:0]     colour0,
  output logic [PIX_W-1:0]     colour1,
  output logic                 enable,
  output logic [COORD_W-1:0]   act_offset,
  output logic [COORD_W-1:0]   act_hpre,
  output logic [COORD_W-1:0]   act_vpre,
  output logic [COORD_W-1:0]   act_posx,
  output logic [COORD_W-1:0]   act_posy
);
  logic [COORD_W-1:0] stg_offset, stg_hpre, stg_vpre, stg_posx, stg_posy;

  // immediate registers
  always_ff @(posedge clk) begin
    if (rst) begin
      colour0 <= '0;
      colour1 <= '0;
      enable  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        SEL_COL0: colour0 <= reg_wdata[PIX_W-1:0];
        SEL_COL1: colour1 <= reg_wdata[PIX_W-1:0];
        SEL_CTRL: enable  <= reg_wdata[EN_BIT];
        default: ;
      endcase
    end
  end

  // staged registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_offset <= '0;
      stg_hpre   <= '0;
      stg_vpre   <= '0;
      stg_posx   <= '0;
      stg_posy   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        SEL_OFFSET: stg_offset <= reg_wdata[COORD_W-1:0];
        SEL_PRESET: begin
          stg_hpre <= reg_wdata[COORD_W-1:0];
          stg_vpre <= reg_wdata[REG_W-1:COORD_W];
        end
        SEL_POS: begin
          stg_posx <= reg_wdata[COORD_W-1:0];
          stg_posy <= reg_wdata[REG_W-1:COORD_W];
        end
        default: ;
      endcase
    end
  end

  // active copies, loaded at vertical blank
  always_ff @(posedge clk) begin
    if (rst) begin
      act_offset <= '0;
      act_hpre   <= '0;
      act_vpre   <= '0;
      act_posx   <= '0;
      act_posy   <= '0;
    end else if (vblank_start) begin
      act_offset <= stg_offset;
      act_hpre   <= stg_hpre;
      act_vpre   <= stg_vpre;
      act_posx   <= stg_posx;
      act_posy   <= stg_posy;
    end
  end
endmodule

// File: rtl/cur_locate.sv
module cur_locate
  import cur_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 11
) (
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic               enable,
  input  logic [COORD_W-1:0] offset,
  input  logic [COORD_W-1:0] hpre,
  input  logic [COORD_W-1:0] vpre,
  input  logic [COORD_W-1:0] posx,
  input  logic [COORD_W-1:0] posy,
  output logic               hit,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [1:0]         pair_sel
);
  logic [COORD_W-1:0] dx, dy;
  logic [COORD_W:0]   col_sum, row_sum;
  logic               in_x, in_y;
  logic [IDX_W-1:0]   col, row;

  always_comb begin
    dx      = beam_x - posx;
    dy      = beam_y - posy;
    col_sum = {1'b0, dx} + {1'b0, hpre};
    row_sum = {1'b0, dy} + {1'b0, vpre};
    in_x    = (beam_x >= posx) && (col_sum < (COORD_W+1)'(CUR_DIM));
    in_y    = (beam_y >= posy) && (row_sum < (COORD_W+1)'(CUR_DIM));
    hit     = enable && in_x && in_y;
    col     = col_sum[IDX_W-1:0];
    row     = dy[IDX_W-1:0];
    pair_sel = col[1:0];
    rd_addr = ADDR_W'({offset, 3'b000})
            + ADDR_W'({row, 4'b0000})
            + ADDR_W'(col[IDX_W-1:2]);
  end
endmodule

// File: rtl/cur_ram.sv
module cur_ram #(
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cur_blend.sv
module cur_blend
  import cur_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [1:0]       pair_sel,
  input  logic [7:0]       img_byte,
  input  logic [PIX_W-1:0] screen,
  input  logic [PIX_W-1:0] colour0,
  input  logic [PIX_W-1:0] colour1,
  output logic [PIX_W-1:0] pix_out
);
  cur_code_e          code;
  logic [PIX_W-1:0]   mixed;

  always_comb begin
    code = cur_code_e'(img_byte[2*pair_sel +: 2]);
    case (code)
      CODE_COL0:   mixed = colour0;
      CODE_COL1:   mixed = colour1;
      CODE_CLEAR:  mixed = screen;
      default:     mixed = ~screen;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= hit ? mixed : screen;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int PIX_W     = 32,
  parameter int COORD_W   = 16,
  parameter int RAM_BYTES = 2048,
  localparam int ADDR_W   = $clog2(RAM_BYTES),
  localparam int REG_W    = 2 * COORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_SEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 vblank_start,
  input  logic                 ram_we,
  input  logic [ADDR_W-1:0]    ram_waddr,
  input  logic [7:0]           ram_wdata,
  input  logic [COORD_W-1:0]   beam_x,
  input  logic [COORD_W-1:0]   beam_y,
  input  logic [PIX_W-1:0]     pix_in,
  output logic [PIX_W-1:0]     pix_out
);
  logic [PIX_W-1:0]   colour0, colour1;
  logic               enable;
  logic [COORD_W-1:0] act_offset, act_hpre, act_vpre, act_posx, act_posy;
  logic               hit;
  logic [ADDR_W-1:0]  rd_addr;
  logic [1:0]         pair_sel;
  logic [7:0]         ram_rdata;
  logic               s1_hit;
  logic [1:0]         s1_pair;
  logic [PIX_W-1:0]   s1_pix;

  cur_regs #(.PIX_W(PIX_W), .COORD_W(COORD_W)) i_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vblank_start(vblank_start),
    .colour0(colour0), .colour1(colour1), .enable(enable),
    .act_offset(act_offset), .act_hpre(act_hpre), .act_vpre(act_vpre),
    .act_posx(act_posx), .act_posy(act_posy)
  );

  cur_locate #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) i_locate (
    .beam_x(beam_x), .beam_y(beam_y), .enable(enable),
    .offset(act_offset), .hpre(act_hpre), .vpre(act_vpre),
    .posx(act_posx), .posy(act_posy),
    .hit(hit), .rd_addr(rd_addr), .pair_sel(pair_sel)
  );

  cur_ram #(.DEPTH(RAM_BYTES)) i_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(ram_rdata)
  );

  // stage 1: align side information with the synchronous RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit  <= 1'b0;
      s1_pair <= '0;
      s1_pix  <= '0;
    end else begin
      s1_hit  <= hit;
      s1_pair <= pair_sel;
      s1_pix  <= pix_in;
    end
  end

  cur_blend #(.PIX_W(PIX_W)) i_blend (
    .clk(clk), .rst(rst), .hit(s1_hit), .pair_sel(s1_pair),
    .img_byte(ram_rdata), .screen(s1_pix),
    .colour0(colour0), .colour1(colour1), .pix_out(pix_out)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PIX_W   = 32,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               vblank_start,
  input logic               enable,
  input logic [PIX_W-1:0]   pix_in,
  input logic [PIX_W-1:0]   pix_out,
  input logic               s1_hit,
  input logic [1:0]         s1_pair,
  input logic [PIX_W-1:0]   s1_pix,
  input logic [7:0]         ram_rdata,
  input logic [COORD_W-1:0] act_posx,
  input logic [COORD_W-1:0] act_posy
);
  logic [1:0] since_rst;
  logic [1:0] seen_code;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign seen_code = ram_rdata[2*s1_pair +: 2];

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pix_out == '0)); // R1

  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && !$past(enable, 2)) |-> (pix_out == $past(pix_in, 2))); // R2

  AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(s1_hit) && $past(seen_code) == 2'b10) |-> (pix_out == $past(s1_pix))); // R3

  AST_INVERT_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(s1_hit) && $past(seen_code) == 2'b11) |-> (pix_out == ~$past(s1_pix))); // R3

  AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !$past(s1_hit)) |-> (pix_out == $past(s1_pix))); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(vblank_start) |-> ($stable(act_posx) && $stable(act_posy))); // R8
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W), .COORD_W(COORD_W)) i_chk (
  .clk(clk), .rst(rst), .vblank_start(vblank_start), .enable(enable),
  .pix_in(pix_in), .pix_out(pix_out), .s1_hit(s1_hit), .s1_pair(s1_pair),
  .s1_pix(s1_pix), .ram_rdata(ram_rdata), .act_posx(act_posx), .act_posy(act_posy)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  localparam int PIX_W = 32;
  localparam int COORD_W = 16;
  localparam int RAM_BYTES = 2048;
  localparam int ADDR_W = $clog2(RAM_BYTES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic vblank_start = 1'b0;
  logic ram_we = 1'b0;
  logic [ADDR_W-1:0] ram_waddr = '0;
  logic [7:0] ram_wdata = '0;
  logic [COORD_W-1:0] beam_x = '0, beam_y = '0;
  logic [PIX_W-1:0] pix_in = '0;
  logic [PIX_W-1:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cursor_overlay #(.PIX_W(PIX_W), .COORD_W(COORD_W), .RAM_BYTES(RAM_BYTES)) i_cursor_overlay (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .vblank_start(vblank_start), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .beam_x(beam_x), .beam_y(beam_y), .pix_in(pix_in),
    .pix_out(pix_out)
  );

  // {x, y, screen pixel, expected}; colours 00FF00FF / 12345678,
  // position (100,50), presets h=4 v=60, offset 8
  localparam logic [95:0] VEC [10] = '{
    {16'd99,  16'd50, 32'h11111111, 32'h11111111},  // R5 left of window
    {16'd100, 16'd50, 32'h22222222, 32'h12345678},  // R6 col 4, code 01
    {16'd101, 16'd50, 32'h33333333, 32'h33333333},  // R4 pair 1, code 10
    {16'd102, 16'd50, 32'h0F0F1234, 32'hF0F0EDCB},  // R3 pair 2, code 11
    {16'd103, 16'd50, 32'h44444444, 32'h00FF00FF},  // R4 pair 3, code 00
    {16'd158, 16'd53, 32'h55555555, 32'h00FF00FF},  // R5 last row
    {16'd160, 16'd53, 32'h66666666, 32'h66666666},  // R5 right edge
    {16'd120, 16'd54, 32'h77777777, 32'h77777777},  // R5 below window
    {16'd120, 16'd49, 32'h88888888, 32'h88888888},  // R5 above window
    {16'd121, 16'd52, 32'h99999999, 32'h12345678}   // R4 row 2
  };

  task automatic check(input string tag, input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank_start = 1'b1;
    @(negedge clk);
    vblank_start = 1'b0;
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [31:0] p);
    @(negedge clk);
    beam_x = x; beam_y = y; pix_in = p;
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] img_byte(input int a);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) b[2*k +: 2] = 2'((a + (a >> 4) + k) & 3);
    return b;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset output", pix_out, '0);
    @(negedge clk);
    rst = 1'b0;
    // R2: disabled after reset, beam inside default window
    apply(16'd0, 16'd0, 32'hCAFE0001);
    check("R2 disabled pass-through", pix_out, 32'hCAFE0001);

    for (int a = 0; a < RAM_BYTES; a++) begin
      @(negedge clk);
      ram_we = 1'b1; ram_waddr = ADDR_W'(a); ram_wdata = img_byte(a);
    end
    @(negedge clk);
    ram_we = 1'b0;

    wreg(3'd0, 32'h00FF00FF);
    wreg(3'd1, 32'h12345678);
    wreg(3'd2, 32'd8);
    wreg(3'd3, {16'd60, 16'd4});
    wreg(3'd4, {16'd50, 16'd100});
    wreg(3'd5, 32'h0000007F);
    pulse_vblank();
    // R10: bits other than 7 do not enable
    apply(16'd100, 16'd50, 32'hABCDEF01);
    check("R10 low control bits ignored", pix_out, 32'hABCDEF01);
    wreg(3'd5, 32'h00000080);

    for (int i = 0; i < 10; i++) begin
      apply(VEC[i][95:80], VEC[i][79:64], VEC[i][63:32]);
      check($sformatf("R3 R4 R5 R6 vector %0d", i), pix_out, VEC[i][31:0]);
    end

    // R8: staged position
    wreg(3'd4, {16'd50, 16'd300});
    apply(16'd100, 16'd50, 32'h0BAD0BAD);
    check("R8 position held before blank", pix_out, 32'h12345678);
    pulse_vblank();
    apply(16'd100, 16'd50, 32'h0BAD0BAD);
    check("R8 old location released", pix_out, 32'h0BAD0BAD);

    // R7: offset +2 skips one row
    wreg(3'd2, 32'd10);
    pulse_vblank();
    apply(16'd300, 16'd50, 32'h5A5A5A5A);
    check("R7 offset row skip", pix_out, 32'h5A5A5A5A);
    apply(16'd303, 16'd50, 32'h5A5A5A5A);
    check("R7 offset row skip colour1", pix_out, 32'h12345678);

    // R11: colour applies without blank
    wreg(3'd1, 32'hDEADBEEF);
    apply(16'd303, 16'd50, 32'h5A5A5A5A);
    check("R11 colour immediate", pix_out, 32'hDEADBEEF);

    // R9: two-edge latency
    apply(16'd0, 16'd0, 32'hAAAA0000);
    @(negedge clk);
    pix_in = 32'hBBBB1111;
    @(posedge clk); #1;
    check("R9 one edge later still old", pix_out, 32'hAAAA0000);
    @(posedge clk); #1;
    check("R9 two edges later new", pix_out, 32'hBBBB1111);

    // R12: preset register halves
    wreg(3'd3, {16'd62, 16'd0});
    pulse_vblank();
    apply(16'd300, 16'd52, 32'h13579BDF);
    check("R12 vertical preset field", pix_out, 32'h13579BDF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule